// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral with a 16-bit up-counter that advances once per prescaled tick while enabled. When the counter wraps from all ones back to zero, the block raises a one-cycle reset request and latches a sticky overflow flag. Software arms the timer by loading `65536 - N` into the counter, which yields a timeout of N prescaled ticks. Loading `0xFFFF` makes the timer overflow on the very next tick.

All three registers sit behind a 32-bit bus. A write is accepted only if its upper bits carry the key pattern of the register it targets; any other write is dropped. An accepted write is first held in a staging register. During a fixed settling window a busy bit reads 1, and the staged values are applied when that window closes. Software therefore waits for the busy bit to clear before it sets the enable.

The block has two resets. Power-on reset clears everything. The system reset, which the watchdog itself normally drives through its reset request, clears everything except the overflow flag. Software can therefore read the flag after a restart to learn that the watchdog caused it.

Top module: `guard_timer`

## Requirements
- R1: Byte offset 0 reads the live count, zero-extended to 32 bits. Offset 4 reads the control/status byte with enable at bit 7, busy at bit 5, overflow flag at bit 4, prescaler code at bits 2:0, and zeros elsewhere. Offset 8 reads the stored control-B byte. Any other offset reads 0.
- R2: A write to offset 0 is accepted only if bits 31:16 are 0x5A5A. Bits 15:0 then become the new count.
- R3: A write to offset 4 or offset 8 is accepted only if bits 31:8 are 0xA5A5A5. Bits 7:0 then carry the data.
- R4: A write with a wrong key, or to an unmapped offset, changes no register, no count and no busy bit.
- R5: After an accepted write, busy reads 1 for exactly two clock cycles. The staged value takes effect on the edge where busy drops. An accepted write during that window restarts it, and all staged values then take effect together.
- R6: Prescaler codes 0 through 7 divide the clock by 1, 4, 16, 32, 64, 128, 1024 and 4096.
- R7: The count rises by one per prescaled tick while enable is set, and holds its value while enable is clear.
- R8: A count loaded with 65536-N overflows on the Nth tick: it wraps to 0 and keeps counting, and the reset request is high for exactly one cycle. A loaded value of 0xFFFF overflows on the first tick.
- R9: Overflow sets the flag. The flag stays set until a keyed write to offset 4 with bit 4 equal to 0 takes effect; writing 1 to bit 4 does not set it. The flag survives the system reset and is cleared only by power-on reset.
- R10: The prescaler divider restarts from zero each time the enable goes from 0 to 1, so the first tick after re-enabling comes a full division period later.
- R11: After either reset, the count, enable, prescaler code, control-B byte, busy bit and reset request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the bus |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | System reset, active low, clears all state except the overflow flag |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data with the key in the upper bits |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wdt_rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The bench sweeps every prescaler code. For each code it checks the count one tick in, one cycle before the overflow and at the overflow itself. A wrong divide table, an off-by-one tick comparison, or a reset request that lasts more than one cycle would all show up as a miscompare on a specific cycle. Near-miss keys are fed to every register. A key checker that compares too few bits would then let a value through. The bench also reads the busy bit and the count in each cycle of the settling window, so a design that applied the value early, or did not restart the window on a second write, would read back the wrong count. Finally, it disables and re-enables partway through a division period, and it pulses the system reset after an overflow. These steps expose a divider that resumes instead of restarting, and a flag that the wrong reset clears.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

  localparam int unsigned DIVCNT_W   = 12;
  localparam int unsigned CTL_BYTE_W = 8;
  localparam int unsigned BIT_EN     = 7;
  localparam int unsigned BIT_BUSY   = 5;
  localparam int unsigned BIT_FLAG   = 4;

  typedef struct packed {
    logic       en;
    logic [2:0] cks;
  } ctrl_t;

  // Terminal value of the divider for each prescaler code (ratio - 1).
  function automatic logic [DIVCNT_W-1:0] div_limit(input logic [2:0] code);
    logic [DIVCNT_W:0] ratio;
    int unsigned       sh;
    case (code)
      3'd0:    sh = 0;
      3'd1:    sh = 2;
      3'd2:    sh = 4;
      3'd3:    sh = 5;
      3'd4:    sh = 6;
      3'd5:    sh = 7;
      3'd6:    sh = 10;
      default: sh = 12;
    endcase
    ratio = (DIVCNT_W+1)'(1) << sh;
    ratio = ratio - (DIVCNT_W+1)'(1);
    return ratio[DIVCNT_W-1:0];
  endfunction

endpackage

// File: rtl/gtmr_rst_sync.sv
module gtmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale
  import gtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] cks,
  output logic       tick
);

  logic [DIVCNT_W-1:0] div_q;
  logic [DIVCNT_W-1:0] div_d;
  logic [DIVCNT_W-1:0] limit;

  assign limit = div_limit(cks);
  assign tick  = en && (div_q >= limit);

  // Divider is held at zero while disabled: a rising enable restarts it.
  always_comb begin
    if (!en)       div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + DIVCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             rst_req
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             req_q;

  assign ovf_evt = tick && (&cnt_q) && !load;

  always_comb begin
    if (load)      cnt_d = ld_val;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= ovf_evt;
    end
  end

  assign count   = cnt_q;
  assign rst_req = req_q;

endmodule

// File: rtl/gtmr_regs.sv
module gtmr_regs
  import gtmr_pkg::*;
#(
  parameter int unsigned DAT_W    = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PEND_CYC = 2,
  parameter logic [DAT_W-CNT_W-1:0]      CNT_KEY = 'h5A5A,
  parameter logic [DAT_W-CTL_BYTE_W-1:0] CTL_KEY = 'hA5A5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DAT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovf_evt,
  output logic [DAT_W-1:0]  bus_rdata,
  output ctrl_t             ctrl,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_ld_val,
  output logic              busy,
  output logic              ovf_flag,
  output logic              wr_hit,
  output logic              flag_clr
);

  localparam int unsigned PEND_W = $clog2(PEND_CYC + 1);
  localparam logic [ADDR_W-1:0] OFF_CNT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_A   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_B   = ADDR_W'(8);

  logic                  wr_req, hit_cnt, hit_a, hit_b, apply;
  logic [PEND_W-1:0]     pend_q, pend_d;
  logic [CNT_W-1:0]      stg_cnt_q, stg_cnt_d;
  logic                  stg_cnt_v_q, stg_cnt_v_d;
  ctrl_t                 stg_a_q, stg_a_d;
  logic                  stg_fb_q, stg_fb_d;
  logic                  stg_a_v_q, stg_a_v_d;
  logic [CTL_BYTE_W-1:0] stg_b_q, stg_b_d;
  logic                  stg_b_v_q, stg_b_v_d;
  ctrl_t                 ctrl_q, ctrl_d;
  logic [CTL_BYTE_W-1:0] regb_q, regb_d;
  logic                  flag_q, flag_d;
  logic [CTL_BYTE_W-1:0] rd_a;

  // Key check and decode
  assign wr_req  = bus_sel && bus_wr;
  assign hit_cnt = wr_req && (bus_addr == OFF_CNT) &&
                   (bus_wdata[DAT_W-1:CNT_W] == CNT_KEY);
  assign hit_a   = wr_req && (bus_addr == OFF_A) &&
                   (bus_wdata[DAT_W-1:CTL_BYTE_W] == CTL_KEY);
  assign hit_b   = wr_req && (bus_addr == OFF_B) &&
                   (bus_wdata[DAT_W-1:CTL_BYTE_W] == CTL_KEY);
  assign wr_hit  = hit_cnt || hit_a || hit_b;
  assign apply   = (pend_q == PEND_W'(1)) && !wr_hit;

  // Next state
  always_comb begin
    pend_d      = pend_q;
    stg_cnt_d   = stg_cnt_q;
    stg_cnt_v_d = stg_cnt_v_q;
    stg_a_d     = stg_a_q;
    stg_fb_d    = stg_fb_q;
    stg_a_v_d   = stg_a_v_q;
    stg_b_d     = stg_b_q;
    stg_b_v_d   = stg_b_v_q;
    ctrl_d      = ctrl_q;
    regb_d      = regb_q;

    if (wr_hit)              pend_d = PEND_W'(PEND_CYC);
    else if (pend_q != '0)   pend_d = pend_q - PEND_W'(1);

    if (hit_cnt) begin
      stg_cnt_d   = bus_wdata[CNT_W-1:0];
      stg_cnt_v_d = 1'b1;
    end else if (apply) begin
      stg_cnt_v_d = 1'b0;
    end

    if (hit_a) begin
      stg_a_d.en  = bus_wdata[BIT_EN];
      stg_a_d.cks = bus_wdata[2:0];
      stg_fb_d    = bus_wdata[BIT_FLAG];
      stg_a_v_d   = 1'b1;
    end else if (apply) begin
      stg_a_v_d   = 1'b0;
    end

    if (hit_b) begin
      stg_b_d   = bus_wdata[CTL_BYTE_W-1:0];
      stg_b_v_d = 1'b1;
    end else if (apply) begin
      stg_b_v_d = 1'b0;
    end

    if (apply && stg_a_v_q) ctrl_d = stg_a_q;
    if (apply && stg_b_v_q) regb_d = stg_b_q;
  end

  assign flag_clr   = apply && stg_a_v_q && !stg_fb_q;
  assign cnt_load   = apply && stg_cnt_v_q;
  assign cnt_ld_val = stg_cnt_q;

  // Set by overflow wins over a clear applied in the same cycle
  always_comb begin
    if (ovf_evt)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  // Registers in the system reset domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      stg_cnt_q   <= '0;
      stg_cnt_v_q <= 1'b0;
      stg_a_q     <= '0;
      stg_fb_q    <= 1'b0;
      stg_a_v_q   <= 1'b0;
      stg_b_q     <= '0;
      stg_b_v_q   <= 1'b0;
      ctrl_q      <= '0;
      regb_q      <= '0;
    end else begin
      pend_q      <= pend_d;
      stg_cnt_q   <= stg_cnt_d;
      stg_cnt_v_q <= stg_cnt_v_d;
      stg_a_q     <= stg_a_d;
      stg_fb_q    <= stg_fb_d;
      stg_a_v_q   <= stg_a_v_d;
      stg_b_q     <= stg_b_d;
      stg_b_v_q   <= stg_b_v_d;
      ctrl_q      <= ctrl_d;
      regb_q      <= regb_d;
    end
  end

  // Overflow flag lives in the power-on domain only
  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n) flag_q <= 1'b0;
    else             flag_q <= flag_d;
  end

  assign busy     = (pend_q != '0);
  assign ovf_flag = flag_q;
  assign ctrl     = ctrl_q;

  // Read path
  always_comb begin
    rd_a           = '0;
    rd_a[BIT_EN]   = ctrl_q.en;
    rd_a[BIT_BUSY] = busy;
    rd_a[BIT_FLAG] = flag_q;
    rd_a[2:0]      = ctrl_q.cks;
    bus_rdata      = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_CNT: bus_rdata = DAT_W'(count);
        OFF_A:   bus_rdata = DAT_W'(rd_a);
        OFF_B:   bus_rdata = DAT_W'(regb_q);
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gtmr_pkg::*;
#(
  parameter int unsigned DAT_W      = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PEND_CYC   = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DAT_W-1:0]  bus_wdata,
  output logic [DAT_W-1:0]  bus_rdata,
  output logic              wdt_rst_req
);

  localparam int unsigned N_DOM = 2;

  logic [N_DOM-1:0] raw_rst_n;
  logic [N_DOM-1:0] sync_rst_n;
  logic             flag_rst_n, sys_rst_n;
  ctrl_t            ctrl;
  logic             tick, cnt_load, ovf_evt, busy, ovf_flag, wr_hit, flag_clr;
  logic [CNT_W-1:0] count, cnt_ld_val;

  assign raw_rst_n[0] = por_n;
  assign raw_rst_n[1] = por_n & rst_n;

  for (genvar g = 0; g < N_DOM; g++) begin : g_rst
    gtmr_rst_sync #(.STAGES(RST_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (raw_rst_n[g]),
      .srst_n (sync_rst_n[g])
    );
  end

  assign flag_rst_n = sync_rst_n[0];
  assign sys_rst_n  = sync_rst_n[1];

  gtmr_regs #(
    .DAT_W(DAT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PEND_CYC(PEND_CYC)
  ) u_regs (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .flag_rst_n (flag_rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count      (count),
    .ovf_evt    (ovf_evt),
    .bus_rdata  (bus_rdata),
    .ctrl       (ctrl),
    .cnt_load   (cnt_load),
    .cnt_ld_val (cnt_ld_val),
    .busy       (busy),
    .ovf_flag   (ovf_flag),
    .wr_hit     (wr_hit),
    .flag_clr   (flag_clr)
  );

  gtmr_prescale u_pre (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .en    (ctrl.en),
    .cks   (ctrl.cks),
    .tick  (tick)
  );

  gtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .tick    (tick),
    .load    (cnt_load),
    .ld_val  (cnt_ld_val),
    .count   (count),
    .ovf_evt (ovf_evt),
    .rst_req (wdt_rst_req)
  );

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             busy,
  input logic             wr_hit,
  input logic             rst_req,
  input logic             ovf_flag,
  input logic             flag_clr,
  input logic             en,
  input logic             tick,
  input logic             cnt_load,
  input logic [CNT_W-1:0] count
);

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_hit |=> busy);

  assert_busy_cause_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (!wr_hit && !busy) |=> !busy);

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_req |=> !rst_req);

  assert_req_flags_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_req |-> ovf_flag);

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (!en && !cnt_load) |=> $stable(count));

  assert_tick_gate_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    tick |-> en);

endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_ok   (sys_rst_n),
  .busy     (busy),
  .wr_hit   (wr_hit),
  .rst_req  (wdt_rst_req),
  .ovf_flag (ovf_flag),
  .flag_clr (flag_clr),
  .en       (ctrl.en),
  .tick     (tick),
  .cnt_load (cnt_load),
  .count    (count)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;

  logic        clk, por_n, rst_n, bus_sel, bus_wr, wdt_rst_req;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_vec = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  guard_timer i_guard_timer (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1;
    v = bus_rdata;
    bus_sel = 1'b0; bus_addr = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  function automatic int ratio(input int c);
    case (c)
      0: return 1;    1: return 4;    2: return 16;   3: return 32;
      4: return 64;   5: return 128;  6: return 1024; default: return 4096;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 to R11 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    por_n = 1'b1; rst_n = 1'b1;
    #1 por_n = 1'b0; rst_n = 1'b0;
    step(3);
    por_n = 1'b1; rst_n = 1'b1;
    step(4);

    // R11 / R1: reset state and read map
    rd(4'h0, v); check("R11", "count after reset", v, 32'h0);
    rd(4'h4, v); check("R11", "ctl A after reset", v, 32'h0);
    rd(4'h8, v); check("R11", "ctl B after reset", v, 32'h0);
    check("R11", "rst_req after reset", {31'b0, wdt_rst_req}, 32'h0);
    rd(4'hC, v); check("R1", "unmapped read", v, 32'h0);

    // R2 / R5: keyed count write, busy window
    wr(4'h0, 32'h5A5A1234);
    rd(4'h4, v); check("R5", "busy cycle 1", v, 32'h20);
    rd(4'h0, v); check("R5", "count not yet applied", v, 32'h0);
    step(1);
    rd(4'h4, v); check("R5", "busy cycle 2", v, 32'h20);
    step(1);
    rd(4'h4, v); check("R5", "busy cleared", v, 32'h0);
    rd(4'h0, v); check("R2", "count applied", v, 32'h1234);

    // R4: bad keys and unmapped offsets
    wr(4'h0, 32'h5A5B4321);
    rd(4'h4, v); check("R4", "no busy on bad count key", v, 32'h0);
    wr(4'h4, 32'hA5A5A485);
    wr(4'h8, 32'hA4A5A599);
    wr(4'hC, 32'hA5A5A5FF);
    wr(4'h4, 32'h5A5A0085);
    step(3);
    rd(4'h0, v); check("R4", "count unchanged", v, 32'h1234);
    rd(4'h4, v); check("R4", "ctl A unchanged", v, 32'h0);
    rd(4'h8, v); check("R4", "ctl B unchanged", v, 32'h0);

    // R3: keyed control writes
    wr(4'h8, 32'hA5A5A53C); step(2);
    rd(4'h8, v); check("R3", "ctl B stored", v, 32'h3C);
    wr(4'h4, 32'hA5A5A505); step(2);
    rd(4'h4, v); check("R3", "ctl A code", v, 32'h05);

    // R5: second write restarts window, both apply together
    wr(4'h0, 32'h5A5A0042);
    wr(4'h8, 32'hA5A5A577);
    step(1);
    rd(4'h0, v); check("R5", "count held by restart", v, 32'h1234);
    rd(4'h8, v); check("R5", "ctl B held by restart", v, 32'h3C);
    step(1);
    rd(4'h0, v); check("R5", "count after restart", v, 32'h0042);
    rd(4'h8, v); check("R5", "ctl B after restart", v, 32'h77);

    // R6 / R8: sweep all prescaler codes, N = 3 ticks
    for (int c = 0; c < 8; c++) begin
      int d;
      d = ratio(c);
      wr(4'h4, 32'hA5A5A500); step(2);
      wr(4'h0, 32'h5A5A0000 | 32'(65536 - 3));
      wr(4'h4, 32'hA5A5A580 | 32'(c));
      step(2);
      step(d);
      rd(4'h0, v); check("R6", "count after one tick", v, 32'hFFFE);
      step(2 * d - 1);
      rd(4'h0, v); check("R6", "count before overflow", v, 32'hFFFF);
      check("R8", "no request before overflow", {31'b0, wdt_rst_req}, 32'h0);
      step(1);
      check("R8", "request at overflow", {31'b0, wdt_rst_req}, 32'h1);
      rd(4'h0, v); check("R8", "count wrapped", v, 32'h0);
      rd(4'h4, v); check("R9", "flag set", v, 32'h90 | 32'(c));
      step(1);
      check("R8", "request one cycle", {31'b0, wdt_rst_req}, 32'h0);
    end

    // R9: flag stickiness and reset domains; R8 immediate overflow
    wr(4'h4, 32'hA5A5A500); step(2);
    wr(4'h0, 32'h5A5AFFFF);
    wr(4'h4, 32'hA5A5A580);
    step(2);
    step(1);
    check("R8", "0xFFFF overflows on first tick", {31'b0, wdt_rst_req}, 32'h1);
    wr(4'h4, 32'hA5A5A510); step(2);
    rd(4'h4, v); check("R9", "writing 1 keeps flag", v, 32'h10);
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(4);
    rd(4'h4, v); check("R9", "flag survives system reset", v, 32'h10);
    rd(4'h0, v); check("R11", "count cleared by system reset", v, 32'h0);
    rd(4'h8, v); check("R11", "ctl B cleared by system reset", v, 32'h0);
    wr(4'h4, 32'hA5A5A500); step(2);
    rd(4'h4, v); check("R9", "flag cleared by write 0", v, 32'h0);
    wr(4'h0, 32'h5A5AFFFF);
    wr(4'h4, 32'hA5A5A580);
    step(3);
    wr(4'h4, 32'hA5A5A510); step(2);
    rd(4'h4, v); check("R9", "flag set again", v, 32'h10);
    por_n = 1'b0; step(2); por_n = 1'b1; step(4);
    rd(4'h4, v); check("R9", "flag cleared by power-on reset", v, 32'h0);

    // R10: divider restarts on re-enable (code 2, divide by 16)
    wr(4'h0, 32'h5A5AFFFF);
    wr(4'h4, 32'hA5A5A582);
    step(2);
    step(8);
    wr(4'h4, 32'hA5A5A502);
    step(2);
    step(3);
    rd(4'h0, v); check("R10", "no tick before disable", v, 32'hFFFF);
    wr(4'h4, 32'hA5A5A582);
    step(2);
    step(15);
    check("R10", "no request before full period", {31'b0, wdt_rst_req}, 32'h0);
    step(1);
    check("R10", "request after full period", {31'b0, wdt_rst_req}, 32'h1);

    // R7: count by one per tick, hold while disabled
    wr(4'h4, 32'hA5A5A500); step(2);
    wr(4'h0, 32'h5A5A0100);
    wr(4'h4, 32'hA5A5A580);
    step(2);
    step(5);
    rd(4'h0, v); check("R7", "count rises per tick", v, 32'h0105);
    wr(4'h4, 32'hA5A5A500);
    step(2);
    rd(4'h0, v); check("R7", "count at disable", v, 32'h0108);
    step(20);
    rd(4'h0, v); check("R7", "count held while disabled", v, 32'h0108);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule